// File: doc/BRIEF.md
# Blinking Seven-Segment Lock Status Display

This block drives a multiplexed, common-anode seven-segment display with eight anode positions for a PIN-protected lock. It takes five inputs: the lock status, a flag that marks PIN entry in progress, three 4-bit digit values, the index of the digit being edited, and a slow blink phase of about 4 Hz. It time-multiplexes one glyph per anode slot. Both the anode enables and the cathode pattern are active-low.

With no entry in progress, the display shows a four-letter status word. The word is `OPEN` when the lock is unlocked and `CLSD` when it is locked. During entry, the display shows the three hex digits. While the blink phase is low, the digit being edited is blanked and the other digits stay lit. Only positions 0 to 3 ever carry content, so the same scan also suits a four-digit display. A refresh counter, derived from the clock rate and the target per-digit refresh rate, sets how long each slot is held.

Top module: `ssd_status_display`

## Requirements
- R1: While `rst` is high, every bit of `an_n` is 1 and `seg_n` is `7'b1111111` (all segments off).
- R2: At most one bit of `an_n` is 0 in any cycle.
- R3: Bits 7 to 4 of `an_n` are always 1. The scan still spends a time slot on each of those positions, and each of those slots is dark.
- R4: When `entering` is 0 and `locked` is 0, the display spells OPEN. Position 3 shows O (`0000001`), position 2 shows P (`0011000`), position 1 shows E (`0110000`) and position 0 shows N (`0001001`). `seg_n` is ordered a,b,c,d,e,f,g from MSB to LSB, and a 0 lights a segment.
- R5: When `entering` is 0 and `locked` is 1, the display spells CLSD. Position 3 shows C (`0110001`), position 2 shows L (`1110001`), position 1 shows S (`0100100`) and position 0 shows D (`1000010`).
- R6: When `entering` is 1, position k (k = 0, 1, 2) shows `digits[4k+3:4k]` in hex, and position 3 is blank.
- R7: The hex glyphs are as follows: 0=0000001, 1=1001111, 2=0010010, 3=0000110, 4=1001100, 5=0100100, 6=0100000, 7=0001111, 8=0000000, 9=0000100, A=0001000, B=1100000, C=0110001, D=1000010, E=0110000, F=0111000.
- R8: When `entering` is 1 and `blink_on` is 0, the position equal to `active_idx` is blank. The other digit positions keep their hex glyphs.
- R9: When `entering` is 0, `blink_on` has no effect. The status word stays fully lit.
- R10: When `active_idx` is 3, no digit position is blanked in either blink phase.
- R11: Each anode slot is held for CLK_HZ/(REFRESH_HZ*8) cycles. The slots are visited in the order 0, 1, ..., 7 and then repeat, so one full scan takes 8 times the slot length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| locked | input | 1 | Lock status: 1 = locked |
| entering | input | 1 | PIN entry in progress |
| digits | input | 12 | Three hex digits; digit k sits at bits 4k+3:4k |
| active_idx | input | 2 | Index of the digit being edited |
| blink_on | input | 1 | Blink phase: 0 = blank the edited digit |
| an_n | output | 8 | Anode enables, active low |
| seg_n | output | 7 | Cathodes a..g (MSB..LSB), active low |

## Verification
The hardest case to reach is a blanked digit. It needs entry mode, the off blink phase and the scan slot equal to the edited index all at once, while the neighbouring slots must stay lit. The bench builds this with a short refresh slot. It holds the inputs steady, waits for the anode pattern of the target position to appear, and then samples the cathodes. It repeats this for each position under the same inputs, so a blanked slot is always compared against lit neighbours. An out-of-range edit index is driven in the off phase to show that no digit is blanked.

// File: rtl/ssd_pkg.sv
package ssd_pkg;

  typedef logic [6:0] seg_t;

  localparam seg_t SEG_BLANK = 7'b1111111;

  typedef enum logic [2:0] {
    LT_O, LT_P, LT_E, LT_N, LT_C, LT_L, LT_S, LT_D
  } letter_e;

  // active-low glyph for a hex nibble, bit 6 = segment a
  function automatic seg_t hex_to_seg(input logic [3:0] v);
    seg_t s;
    case (v)
      4'h0: s = 7'b0000001;
      4'h1: s = 7'b1001111;
      4'h2: s = 7'b0010010;
      4'h3: s = 7'b0000110;
      4'h4: s = 7'b1001100;
      4'h5: s = 7'b0100100;
      4'h6: s = 7'b0100000;
      4'h7: s = 7'b0001111;
      4'h8: s = 7'b0000000;
      4'h9: s = 7'b0000100;
      4'hA: s = 7'b0001000;
      4'hB: s = 7'b1100000;
      4'hC: s = 7'b0110001;
      4'hD: s = 7'b1000010;
      4'hE: s = 7'b0110000;
      default: s = 7'b0111000;
    endcase
    return s;
  endfunction

  function automatic seg_t letter_to_seg(input letter_e l);
    seg_t s;
    case (l)
      LT_O: s = hex_to_seg(4'h0);
      LT_P: s = 7'b0011000;
      LT_E: s = hex_to_seg(4'hE);
      LT_N: s = 7'b0001001;
      LT_C: s = hex_to_seg(4'hC);
      LT_L: s = 7'b1110001;
      LT_S: s = hex_to_seg(4'h5);
      default: s = hex_to_seg(4'hD);
    endcase
    return s;
  endfunction

  // slot 3 carries the first letter of the word
  function automatic letter_e word_letter(input logic locked, input logic [1:0] slot);
    letter_e l;
    case ({locked, slot})
      3'b0_11: l = LT_O;
      3'b0_10: l = LT_P;
      3'b0_01: l = LT_E;
      3'b0_00: l = LT_N;
      3'b1_11: l = LT_C;
      3'b1_10: l = LT_L;
      3'b1_01: l = LT_S;
      default: l = LT_D;
    endcase
    return l;
  endfunction

  // active-low anode pattern for one scan slot; slots at or above lit_pos stay dark
  function automatic logic [7:0] slot_anodes(input logic [2:0] pos, input int lit_pos);
    logic [7:0] a;
    a = 8'hFF;
    if (int'(pos) < lit_pos) a[pos] = 1'b0;
    return a;
  endfunction

endpackage

// File: rtl/ssd_scan_timer.sv
module ssd_scan_timer #(
  parameter int DWELL   = 12500,
  parameter int NUM_POS = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  output logic [$clog2(NUM_POS)-1:0] pos,
  output logic                       slot_end
);
  localparam int POS_W  = $clog2(NUM_POS);
  localparam int TICK_W = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(DWELL - 1);
  localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(NUM_POS - 1);

  logic [TICK_W-1:0] tick;

  assign slot_end = (tick == TICK_LAST);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      tick <= '0;
      pos  <= '0;
    end else if (slot_end) begin
      tick <= '0;
      pos  <= (pos == POS_LAST) ? '0 : pos + 1'b1;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  // R11
  dwell_bound_chk: assert property (@(posedge clk) disable iff (rst)
    tick <= TICK_LAST);

  // R11
  pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !slot_end |=> $stable(pos));

endmodule

// File: rtl/ssd_glyph_mux.sv
module ssd_glyph_mux
  import ssd_pkg::*;
#(
  parameter int NUM_DIGITS = 3,
  parameter int POS_W      = 3,
  parameter int IDX_W      = 2,
  parameter int LIT_POS    = 4
) (
  input  logic [POS_W-1:0]        pos,
  input  logic                    locked,
  input  logic                    entering,
  input  logic [NUM_DIGITS*4-1:0] digits,
  input  logic [IDX_W-1:0]        active_idx,
  input  logic                    blink_on,
  output seg_t                    seg,
  output logic                    hide_evt
);
  seg_t dig_seg  [NUM_DIGITS];
  logic [NUM_DIGITS-1:0] dig_hide;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
    assign dig_seg[g]  = hex_to_seg(digits[g*4 +: 4]);
    assign dig_hide[g] = entering && !blink_on && (active_idx == IDX_W'(g));
  end

  always_comb begin
    seg      = SEG_BLANK;
    hide_evt = 1'b0;
    if (int'(pos) < LIT_POS) begin
      if (entering) begin
        for (int k = 0; k < NUM_DIGITS; k++) begin
          if (pos == POS_W'(k)) begin
            seg      = dig_hide[k] ? SEG_BLANK : dig_seg[k];
            hide_evt = dig_hide[k];
          end
        end
      end else begin
        seg = letter_to_seg(word_letter(locked, pos[1:0]));
      end
    end
  end

endmodule

// File: rtl/ssd_status_display.sv
module ssd_status_display
  import ssd_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int REFRESH_HZ = 1000,
  parameter int NUM_DIGITS = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    locked,
  input  logic                    entering,
  input  logic [NUM_DIGITS*4-1:0] digits,
  input  logic [1:0]              active_idx,
  input  logic                    blink_on,
  output logic [7:0]              an_n,
  output logic [6:0]              seg_n
);
  localparam int NUM_POS   = 8;
  localparam int LIT_POS   = 4;
  localparam int POS_W     = $clog2(NUM_POS);
  localparam int RAW_DWELL = CLK_HZ / (REFRESH_HZ * NUM_POS);
  localparam int DWELL     = (RAW_DWELL < 1) ? 1 : RAW_DWELL;

  logic [POS_W-1:0] pos;
  logic             slot_end;
  seg_t             glyph;
  logic             hide_evt;

  ssd_scan_timer #(.DWELL(DWELL), .NUM_POS(NUM_POS)) u_scan (
    .clk      (clk),
    .rst      (rst),
    .pos      (pos),
    .slot_end (slot_end)
  );

  ssd_glyph_mux #(
    .NUM_DIGITS (NUM_DIGITS),
    .POS_W      (POS_W),
    .IDX_W      (2),
    .LIT_POS    (LIT_POS)
  ) u_glyph (
    .pos        (pos),
    .locked     (locked),
    .entering   (entering),
    .digits     (digits),
    .active_idx (active_idx),
    .blink_on   (blink_on),
    .seg        (glyph),
    .hide_evt   (hide_evt)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      an_n  <= 8'hFF;
      seg_n <= SEG_BLANK;
    end else begin
      an_n  <= slot_anodes(pos, LIT_POS);
      seg_n <= glyph;
    end
  end

  // R2
  one_anode_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~an_n));

  // R3
  dark_upper_chk: assert property (@(posedge clk) disable iff (rst)
    &an_n[NUM_POS-1:LIT_POS]);

  // R8
  blank_active_chk: assert property (@(posedge clk) disable iff (rst)
    (entering && !blink_on && int'(active_idx) < NUM_DIGITS &&
     pos == POS_W'(active_idx)) |=> (seg_n == SEG_BLANK));

  // R9
  word_lit_chk: assert property (@(posedge clk) disable iff (rst)
    (!entering && int'(pos) < LIT_POS) |=> (seg_n != SEG_BLANK));

  // R10
  no_hide_oor_chk: assert property (@(posedge clk) disable iff (rst)
    (active_idx == 2'd3) |-> !hide_evt);

endmodule

// File: tb/sim_ssd_status_display.sv
module sim_ssd_status_display;
  // CLK_HZ/(REFRESH_HZ*8) = 4 cycles per slot
  localparam int DWELL = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        locked = 1'b0;
  logic        entering = 1'b0;
  logic [11:0] digits = '0;
  logic [1:0]  active_idx = '0;
  logic        blink_on = 1'b1;
  logic [7:0]  an_n;
  logic [6:0]  seg_n;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ssd_status_display #(.CLK_HZ(32000), .REFRESH_HZ(1000), .NUM_DIGITS(3)) u0 (
    .clk(clk), .rst(rst), .locked(locked), .entering(entering), .digits(digits),
    .active_idx(active_idx), .blink_on(blink_on), .an_n(an_n), .seg_n(seg_n)
  );

  // fields: req[30:27] locked[26] entering[25] blink[24] idx[23:22] digits[21:10] pos[9:7] exp[6:0]
  localparam int NV = 18;
  localparam logic [30:0] VEC [NV] = '{
    {4'd4,  1'b0,1'b0,1'b1,2'd0,12'h000,3'd3,7'b0000001}, // R4 O
    {4'd4,  1'b0,1'b0,1'b1,2'd0,12'h000,3'd2,7'b0011000}, // R4 P
    {4'd4,  1'b0,1'b0,1'b1,2'd0,12'h000,3'd1,7'b0110000}, // R4 E
    {4'd4,  1'b0,1'b0,1'b1,2'd0,12'h000,3'd0,7'b0001001}, // R4 N
    {4'd5,  1'b1,1'b0,1'b1,2'd0,12'h000,3'd3,7'b0110001}, // R5 C
    {4'd5,  1'b1,1'b0,1'b1,2'd0,12'h000,3'd2,7'b1110001}, // R5 L
    {4'd5,  1'b1,1'b0,1'b1,2'd0,12'h000,3'd1,7'b0100100}, // R5 S
    {4'd5,  1'b1,1'b0,1'b1,2'd0,12'h000,3'd0,7'b1000010}, // R5 D
    {4'd6,  1'b0,1'b1,1'b1,2'd0,12'h7A3,3'd0,7'b0000110}, // R6 digit 3
    {4'd6,  1'b0,1'b1,1'b1,2'd0,12'h7A3,3'd1,7'b0001000}, // R6 digit A
    {4'd6,  1'b0,1'b1,1'b1,2'd0,12'h7A3,3'd2,7'b0001111}, // R6 digit 7
    {4'd6,  1'b1,1'b1,1'b1,2'd0,12'h7A3,3'd3,7'b1111111}, // R6 pos3 blank
    {4'd8,  1'b0,1'b1,1'b0,2'd1,12'h7A3,3'd1,7'b1111111}, // R8 edited blank
    {4'd8,  1'b0,1'b1,1'b0,2'd1,12'h7A3,3'd0,7'b0000110}, // R8 neighbour lit
    {4'd8,  1'b0,1'b1,1'b0,2'd1,12'h7A3,3'd2,7'b0001111}, // R8 neighbour lit
    {4'd9,  1'b1,1'b0,1'b0,2'd3,12'h000,3'd3,7'b0110001}, // R9 word unaffected
    {4'd9,  1'b0,1'b0,1'b0,2'd0,12'h000,3'd0,7'b0001001}, // R9 word unaffected
    {4'd10, 1'b0,1'b1,1'b0,2'd3,12'h7A3,3'd2,7'b0001111}  // R10 nothing blanked
  };

  function automatic logic [6:0] exp_hex(input logic [3:0] v);
    case (v)
      4'h0: return 7'b0000001;  4'h1: return 7'b1001111;
      4'h2: return 7'b0010010;  4'h3: return 7'b0000110;
      4'h4: return 7'b1001100;  4'h5: return 7'b0100100;
      4'h6: return 7'b0100000;  4'h7: return 7'b0001111;
      4'h8: return 7'b0000000;  4'h9: return 7'b0000100;
      4'hA: return 7'b0001000;  4'hB: return 7'b1100000;
      4'hC: return 7'b0110001;  4'hD: return 7'b1000010;
      4'hE: return 7'b0110000;  default: return 7'b0111000;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_pos(input int p);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (an_n == ~(8'h01 << p)) return;
    end
  endtask

  initial begin : watchdog
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int bad_anodes;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 an_n", 32'(an_n), 32'hFF);
    check("R1 seg_n", 32'(seg_n), 32'h7F);
    rst = 1'b0;

    // table walk
    for (int v = 0; v < NV; v++) begin
      locked     = VEC[v][26];
      entering   = VEC[v][25];
      blink_on   = VEC[v][24];
      active_idx = VEC[v][23:22];
      digits     = VEC[v][21:10];
      repeat (2) @(negedge clk);
      wait_pos(int'(VEC[v][9:7]));
      check($sformatf("R%0d vec%0d", VEC[v][30:27], v), 32'(seg_n), 32'(VEC[v][6:0]));
    end

    // R7 every hex value on position 0
    entering = 1'b1; blink_on = 1'b1; active_idx = 2'd0; locked = 1'b0;
    for (int h = 0; h < 16; h++) begin
      digits = {8'h00, 4'(h)};
      repeat (2) @(negedge clk);
      wait_pos(0);
      check($sformatf("R7 hex %0h", h), 32'(seg_n), 32'(exp_hex(4'(h))));
    end

    // R2 / R3 across several full scans
    bad_anodes = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (!$onehot0(~an_n)) bad_anodes++;
    end
    check("R2 single anode", 32'(bad_anodes), 32'd0);
    bad_anodes = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (an_n[7:4] != 4'hF) bad_anodes++;
    end
    check("R3 upper anodes dark", 32'(bad_anodes), 32'd0);

    // R11 slot length and scan period
    wait_pos(0);
    while (an_n == 8'hFE) @(negedge clk);
    check("R11 order 0->1", 32'(an_n), 32'hFD);
    n = 0;
    while (an_n == 8'hFD) begin n++; @(negedge clk); end
    check("R11 slot length", 32'(n), 32'(DWELL));
    check("R11 order 1->2", 32'(an_n), 32'hFB);
    n = DWELL;
    while (an_n != 8'hFD) begin n++; @(negedge clk); end
    check("R11 scan period", 32'(n), 32'(8 * DWELL));

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    #1;
    check("R1 async an_n", 32'(an_n), 32'hFF);
    check("R1 async seg_n", 32'(seg_n), 32'h7F);
    @(negedge clk);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule